// File: doc/BRIEF.md
# Watchdog Timer with Reset Control

The block is an 8-bit up-counter that a selectable prescaler clocks from the system clock. If software stops rewriting the counter and it wraps from 0xFF to 0x00, the block does one of two things. In watchdog mode it pulses an overflow output, latches an overflow flag and can issue a fixed-length internal reset pulse. In interval mode it raises an interrupt pulse and does nothing else. Software reaches a counter register, a control register and a reset control register over a simple single-cycle write bus with a combinational read port.

The reset control register has two protections. A write only takes effect when the upper byte of the 16-bit write data carries the right key. It also keeps its contents through the internal reset that the block generates itself. Only the external reset clears it. This lets software find out, after an internally generated reset, that the watchdog caused it.

Top module: `wdt_rstctl`

## Requirements
- R1: After external reset (rst_ni low), the counter reads 0x00, the control register reads 0x18, the reset control register reads 0x1F, and ovf_o, irq_o and int_rst_o are low.
- R2: While the enable bit (control bit 5) is 0, the counter holds 0x00 and ignores counter writes, and the prescaler is held cleared.
- R3: The clock select field (control bits 2:0) picks a count divide ratio of 2, 64, 128, 256, 512, 1024, 4096 or 8192 for codes 0 to 7. Counting starts from a cleared prescaler on the edge that sets enable, and the counter increments on every N-th edge after that edge.
- R4: When the counter wraps from 0xFF in watchdog mode (control bit 6 = 1), ovf_o is high for exactly the one cycle after the wrap edge. On the same edge the overflow flag (reset control bit 7) is set.
- R5: When the counter wraps in interval mode (control bit 6 = 0), irq_o is high for the one cycle after the wrap edge. ovf_o, the flag and the reset output stay unchanged.
- R6: Control register reads return {0, mode, enable, 1, 1, clock select}, so bits 4 and 3 always read 1. Address 3 reads 0x00. Addresses: 0 counter, 1 control, 2 reset control.
- R7: Reset control reads return {flag, reset enable, reset type, 5'b11111}. A write with upper data byte 0xA5 loads reset enable and reset type from data bits 6 and 5. Writes with any other key leave these bits unchanged.
- R8: A write with upper byte 0x5A and data bit 7 = 0 clears the flag. With data bit 7 = 1, or with any other key, the flag is unchanged. A hardware set on the same edge wins over a clear.
- R9: A watchdog-mode wrap with reset enable set drives int_rst_o high for exactly 512 cycles, starting the cycle after the wrap edge. int_rst_type_o always shows the reset type bit.
- R10: On the edge where the internal reset starts, the counter and the control register return to their reset values. The reset control register keeps its contents, and only the external reset sets it to 0x1F.
- R11: A counter write while enabled loads the write data on that edge, wins over a tick on the same edge, and leaves the prescaler phase untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 counter, 1 control, 2 reset control) |
| wdata_i | input | 16 | Write data, upper byte is the key for the reset control register |
| rdata_o | output | 8 | Combinational read data for addr_i |
| ovf_o | output | 1 | Watchdog overflow pulse |
| irq_o | output | 1 | Interval-mode overflow interrupt pulse |
| int_rst_o | output | 1 | Internal reset pulse |
| int_rst_type_o | output | 1 | Reset type select that goes with int_rst_o |

## Verification
A register write lands on the edge where wr_i is sampled, so its effect shows on rdata_o in the half cycle after that edge. For a divide ratio N, counter increments fall N, 2N, ... edges after the enabling write. ovf_o, irq_o, the flag and the start of int_rst_o follow the wrap edge by exactly one register, and int_rst_o then stays high for 512 cycles. The bench keeps a behavioural model that it steps on each rising edge. It compares every output 1 ns after that edge, while inputs change only on falling edges. The bench also reads back registers at hand-computed points.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W   = 8;
  localparam int PRESC_W = 13;

  typedef struct packed {
    logic       mode;  // 1: watchdog, 0: interval
    logic       en;
    logic [2:0] cks;
  } wdt_ctrl_t;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_RST  = 2'd2;

  // low-bit mask: tick when all masked prescaler bits are set
  function automatic logic [PRESC_W-1:0] div_mask(input logic [2:0] cks);
    case (cks)
      3'd0:    div_mask = PRESC_W'(1);
      3'd1:    div_mask = PRESC_W'(63);
      3'd2:    div_mask = PRESC_W'(127);
      3'd3:    div_mask = PRESC_W'(255);
      3'd4:    div_mask = PRESC_W'(511);
      3'd5:    div_mask = PRESC_W'(1023);
      3'd6:    div_mask = PRESC_W'(4095);
      default: div_mask = PRESC_W'(8191);
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] cks_i,
  output logic       tick_o
);
  logic [PRESC_W-1:0] presc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    presc_q <= '0;
    else if (!en_i) presc_q <= '0;
    else            presc_q <= presc_q + 1'b1;
  end

  assign tick_o = en_i && (&(presc_q | ~div_mask(cks_i)));

  assert_presc_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> presc_q == '0);
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int CYCLES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (start_i)         left_q <= W'(CYCLES);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

  assert_pulse_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pulse_o);
  assert_pulse_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && left_q > W'(1)) |=> pulse_o);
endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl
  import wdt_pkg::*;
#(
  parameter int         RST_CYCLES = 512,
  parameter logic [7:0] KEY_CFG    = 8'hA5,
  parameter logic [7:0] KEY_CLR    = 8'h5A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  rdata_o,
  output logic        ovf_o,
  output logic        irq_o,
  output logic        int_rst_o,
  output logic        int_rst_type_o
);
  wdt_ctrl_t        ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, rste_q, rsts_q;
  logic             tick, wrap, wd_ovf, it_ovf, rst_fire;
  logic             wr_cnt, wr_ctrl, key_cfg, key_clr;

  wdt_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.en),
    .cks_i  (ctrl_q.cks),
    .tick_o (tick)
  );

  wdt_rst_pulse #(.CYCLES(RST_CYCLES)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rst_fire),
    .pulse_o (int_rst_o)
  );

  always_comb begin
    wr_cnt   = wr_i && addr_i == ADDR_CNT;
    wr_ctrl  = wr_i && addr_i == ADDR_CTRL;
    key_cfg  = wr_i && addr_i == ADDR_RST && wdata_i[15:8] == KEY_CFG;
    key_clr  = wr_i && addr_i == ADDR_RST && wdata_i[15:8] == KEY_CLR && !wdata_i[7];
    wrap     = tick && (&cnt_q) && !wr_cnt;  // counter write wins over a tick
    wd_ovf   = wrap && ctrl_q.mode;
    it_ovf   = wrap && !ctrl_q.mode;
    rst_fire = wd_ovf && rste_q;

    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = '{mode: wdata_i[6], en: wdata_i[5], cks: wdata_i[2:0]};
    if (rst_fire) ctrl_d = '0;

    if (!ctrl_d.en)   cnt_d = '0;
    else if (wr_cnt)  cnt_d = wdata_i[CNT_W-1:0];
    else if (tick)    cnt_d = cnt_q + 1'b1;
    else              cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      ovf_o  <= wd_ovf;
      irq_o  <= it_ovf;
    end
  end

  // only the external reset touches this register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      rste_q <= 1'b0;
      rsts_q <= 1'b0;
    end else begin
      if (wd_ovf)       flag_q <= 1'b1;
      else if (key_clr) flag_q <= 1'b0;
      if (key_cfg) begin
        rste_q <= wdata_i[6];
        rsts_q <= wdata_i[5];
      end
    end
  end

  assign int_rst_type_o = rsts_q;

  always_comb begin
    case (addr_i)
      ADDR_CNT:  rdata_o = cnt_q;
      ADDR_CTRL: rdata_o = {1'b0, ctrl_q.mode, ctrl_q.en, 2'b11, ctrl_q.cks};
      ADDR_RST:  rdata_o = {flag_q, rste_q, rsts_q, 5'b11111};
      default:   rdata_o = 8'h00;
    endcase
  end

  assert_ovf_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> flag_q);
  assert_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && irq_o));
  assert_cnt_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.en |-> cnt_q == '0);
  assert_rst_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_rst_o) |-> (flag_q && rste_q && !ctrl_q.en));
endmodule

// File: tb/tb_wdt_rstctl.sv
`timescale 1ns/1ps
module tb_wdt_rstctl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [7:0]  rdata_o;
  logic        ovf_o, irq_o, int_rst_o, int_rst_type_o;
  int          errs = 0;
  int          checks = 0;

  always #2.5 clk_i = ~clk_i;

  wdt_rstctl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ovf_o(ovf_o), .irq_o(irq_o), .int_rst_o(int_rst_o),
    .int_rst_type_o(int_rst_type_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_presc, m_left, m_cks;
  bit m_mode, m_en, m_flag, m_rste, m_rsts, m_ovf, m_irq;

  function automatic int divn(input int c);
    case (c)
      0: return 2;     1: return 64;   2: return 128;  3: return 256;
      4: return 512;   5: return 1024; 6: return 4096; default: return 8192;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin : model
    int n;
    bit tick, wc, wctl, wrap, fire;
    if (!rst_ni) begin
      m_cnt = 0; m_presc = 0; m_left = 0; m_cks = 0;
      m_mode = 0; m_en = 0; m_flag = 0; m_rste = 0; m_rsts = 0; m_ovf = 0; m_irq = 0;
    end else begin
      n    = divn(m_cks);
      tick = m_en && ((m_presc % n) == n - 1);
      wc   = wr_i && addr_i == 2'd0;
      wctl = wr_i && addr_i == 2'd1;
      wrap = tick && m_cnt == 255 && !wc;
      fire = wrap && m_mode && m_rste;
      m_ovf = wrap && m_mode;
      m_irq = wrap && !m_mode;
      m_presc = m_en ? (m_presc + 1) % 8192 : 0;
      if (wctl) begin
        m_mode = wdata_i[6]; m_en = wdata_i[5]; m_cks = int'(wdata_i[2:0]);
      end
      if (fire) begin
        m_mode = 0; m_en = 0; m_cks = 0;
      end
      if (!m_en)     m_cnt = 0;
      else if (wc)   m_cnt = int'(wdata_i[7:0]);
      else if (tick) m_cnt = (m_cnt + 1) % 256;
      if (wrap && m_mode == 0 && !fire) ; // interval wrap: flag untouched
      if (m_ovf) m_flag = 1;
      else if (wr_i && addr_i == 2'd2 && wdata_i[15:8] == 8'h5A && !wdata_i[7]) m_flag = 0;
      if (wr_i && addr_i == 2'd2 && wdata_i[15:8] == 8'hA5) begin
        m_rste = wdata_i[6]; m_rsts = wdata_i[5];
      end
      if (fire) m_left = 512;
      else if (m_left > 0) m_left--;
    end
  end

  always @(posedge clk_i) begin
    int exp_rd;
    string tag;
    #1;
    if (rst_ni) begin
      case (addr_i)
        2'd0: begin exp_rd = m_cnt; tag = "R3 counter"; end
        2'd1: begin exp_rd = (int'(m_mode) << 6) | (int'(m_en) << 5) | 'h18 | m_cks; tag = "R6 control"; end
        2'd2: begin exp_rd = (int'(m_flag) << 7) | (int'(m_rste) << 6) | (int'(m_rsts) << 5) | 'h1F; tag = "R7 rstctl"; end
        default: begin exp_rd = 0; tag = "R6 unused"; end
      endcase
      chk(tag, rdata_o, exp_rd);
      chk("R4 ovf_o", ovf_o, m_ovf);
      chk("R5 irq_o", irq_o, m_irq);
      chk("R9 int_rst_o", int_rst_o, m_left != 0);
      chk("R9 int_rst_type_o", int_rst_type_o, m_rsts);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(2'd0, 'h00, "R1 counter");
    rd(2'd1, 'h18, "R1 control");
    rd(2'd2, 'h1F, "R1 rstctl");
    chk("R1 outputs", {ovf_o, irq_o, int_rst_o}, 0);
    rd(2'd3, 'h00, "R6 addr3");

    wr(2'd0, 16'h0055);                 // ignored while disabled
    rd(2'd0, 'h00, "R2 write while disabled");

    wr(2'd2, 16'h1160);                 // wrong key
    rd(2'd2, 'h1F, "R7 bad key");
    wr(2'd2, 16'hA560);
    rd(2'd2, 'h7F, "R7 keyed write");

    wr(2'd1, 16'h0060);                 // watchdog, enabled, div 2
    rd(2'd1, 'h78, "R6 control layout");
    idle(1100);
    rd(2'd2, 'hFF, "R10 rstctl kept");
    rd(2'd1, 'h18, "R10 control cleared");
    rd(2'd0, 'h00, "R10 counter cleared");

    wr(2'd2, 16'hA500);
    rd(2'd2, 'h9F, "R7 cfg keeps flag");
    wr(2'd2, 16'h5AFF);
    rd(2'd2, 'h9F, "R8 write one no effect");
    wr(2'd2, 16'h3300);
    rd(2'd2, 'h9F, "R8 bad key");
    wr(2'd2, 16'h5A00);
    rd(2'd2, 'h1F, "R8 clear");

    wr(2'd1, 16'h0021);                 // interval, div 64
    idle(64 * 3);
    rd(2'd0, 'h03, "R3 div64 count");
    idle(16500);
    rd(2'd2, 'h1F, "R5 flag untouched");
    wr(2'd1, 16'h0000);

    wr(2'd1, 16'h0067);                 // watchdog, no reset, div 8192
    idle(100);
    wr(2'd0, 16'h0080);
    rd(2'd0, 'h80, "R11 counter load");
    wr(2'd0, 16'h00FE);
    idle(17000);
    rd(2'd2, 'h9F, "R4 flag set");
    chk("R9 no reset when disabled", int_rst_o, 0);

    wr(2'd1, 16'h0064);                 // div 512
    wr(2'd0, 16'h00F0);
    idle(9000);

    @(negedge clk_i);
    rst_ni = 1'b0;
    rd(2'd2, 'h1F, "R10 external reset");
    idle(2);
    rst_ni = 1'b1;
    idle(5);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule